// File: doc/BRIEF.md
# I/O Address Translation Unit

This block turns device virtual addresses from DMA masters into physical addresses. The translatable region is a window that always ends at 0xFFFFFFFF. A three-bit size code in the control word sets its lower bound. Software programs the unit through a small word-addressed register port. One word holds the enable, the size code and a pair of read-only identity nibbles. A second word holds the page-table base.

Each translation request is checked against the window. A request that passes leads to exactly one 32-bit page-table entry fetch over a simple request/grant/read-data memory port. The entry is then checked for validity and write permission, and the unit returns a response carrying a status code, the physical address, the cacheable hint and the original device address. Only one translation is in flight at a time.

Top module: `iomxu_top`

## Requirements
- R1: After reset the control word reads as {IMPL_ID, VER_ID, 24'h0}, the base word reads 0, and the unit is disabled, so every request gets range status.
- R2: Word 0 is control: bit 0 enables the unit, bits 4:2 are the size code, bits 23:0 read back as written, and bits 31:28 / 27:24 always read IMPL_ID / VER_ID whatever is written. Word 1 is the 32-bit page-table base, read/write. Any other word reads 0. Read data appears the cycle after the read strobe.
- R3: The window lower bound is 0xFFFFFFFF shifted left by (24 + size code), giving 16 MB for code 0 up to 2 GB for code 7. It is captured into a register only when the control word is written.
- R4: A request made while the unit is disabled, or whose address lies below the window lower bound, completes with status 2'b01, a PA of 0 and no memory fetch.
- R5: The entry address fetched is (base << 4) + (((dva - lower bound) >> 10) with bits 1:0 cleared), which is one word per 4 KB page.
- R6: With a valid, permitted entry the status is 2'b00, the PA is {1'b0, entry[26:8], dva[11:0]}, and the cacheable flag is entry bit 7.
- R7: An entry with bit 1 (valid) clear gives status 2'b10 and a PA of 0, for both reads and writes.
- R8: A write request whose entry is valid but has bit 2 (writeable) clear gives status 2'b11 and a PA of 0. A read request to the same entry succeeds.
- R9: Only one translation is outstanding: req_ready is low from the accepting edge until the response handshake completes.
- R10: While rsp_valid is high and rsp_ready is low, the response fields hold steady. While mem_req is high and mem_gnt is low, mem_addr holds steady.
- R11: Every response carries the device address of the request it answers, on rsp_dva.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | REG_AW | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | Request is for a device write |
| req_dva | input | 32 | Device virtual address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_status | output | 2 | 00 ok, 01 range/disabled, 10 invalid entry, 11 write-protected |
| rsp_pa | output | 32 | Translated physical address |
| rsp_dva | output | 32 | Device address of the answered request |
| rsp_cache | output | 1 | Cacheable hint from the entry |
| mem_req | output | 1 | Entry fetch request |
| mem_gnt | input | 1 | Fetch request accepted |
| mem_addr | output | 32 | Entry fetch address |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | 32 | Fetched entry |

## Verification
The bench builds the unit with REG_AW=2, registered read data, and non-zero identity nibbles 4'hA and 5. The wider word index makes the unmapped words 2 and 3 reachable, so their zero readback can be checked. The non-zero nibbles make an ignored write to the identity field visible at the port. Size codes 0, 3 and 7 are each exercised at the window's first byte, its last page and the byte just below it. The memory model varies grant delay and read latency, and a stalled response consumer makes the hold rules observable.

// File: rtl/iomxu_pkg.sv
package iomxu_pkg;

   localparam int XW = 32;

   // control word fields
   localparam int EN_BIT  = 0;
   localparam int RNG_LSB = 2;
   localparam int RNG_W   = 3;
   localparam int CTL_W   = 24;

   // entry fields
   localparam int PTE_V_BIT = 1;
   localparam int PTE_W_BIT = 2;
   localparam int PTE_C_BIT = 7;
   localparam int PPN_LSB   = 8;
   localparam int PPN_MSB   = 26;

   localparam int PG_SHIFT   = 12;
   localparam int BASE_SHIFT = 4;
   localparam int IDX_SHIFT  = PG_SHIFT - 2;
   localparam int MIN_WIN_LG = 24;

   typedef enum logic [1:0] {
      XS_OK      = 2'b00,
      XS_RANGE   = 2'b01,
      XS_INVALID = 2'b10,
      XS_WPROT   = 2'b11
   } xl_status_e;

   function automatic logic [XW-1:0] win_lower_f(input logic [RNG_W-1:0] code);
      logic [5:0] sh;
      sh = 6'(MIN_WIN_LG) + {3'b000, code};
      return {XW{1'b1}} << sh;
   endfunction

endpackage

// File: rtl/iomxu_regs.sv
module iomxu_regs
   import iomxu_pkg::*;
#(
   parameter int         REG_AW    = 2,
   parameter bit         RDATA_REG = 1'b1,
   parameter logic [3:0] IMPL_ID   = 4'h1,
   parameter logic [3:0] VER_ID    = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] addr,
   input  logic [XW-1:0]     wdata,
   output logic [XW-1:0]     rdata,
   output logic              enable,
   output logic [XW-1:0]     win_lower,
   output logic [XW-1:0]     pt_base
);

   localparam logic [REG_AW-1:0] CTL_IDX  = REG_AW'(0);
   localparam logic [REG_AW-1:0] BASE_IDX = REG_AW'(1);

   logic [CTL_W-1:0] ctl_q;
   logic [XW-1:0]    base_q;
   logic [XW-1:0]    lower_q;
   logic [XW-1:0]    rd_mux;
   logic             ctl_wr;
   logic             unused_ro;

   assign ctl_wr    = wr_en && (addr == CTL_IDX);
   assign unused_ro = ^wdata[XW-1:CTL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         base_q  <= '0;
         lower_q <= win_lower_f('0);
      end else begin
         if (ctl_wr) begin
            ctl_q   <= wdata[CTL_W-1:0];
            lower_q <= win_lower_f(wdata[RNG_LSB +: RNG_W]);
         end
         if (wr_en && addr == BASE_IDX)
            base_q <= wdata;
      end
   end

   always_comb begin
      if (addr == CTL_IDX)       rd_mux = {IMPL_ID, VER_ID, ctl_q};
      else if (addr == BASE_IDX) rd_mux = base_q;
      else                       rd_mux = '0;
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [XW-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (rd_en) rd_q <= rd_mux;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? rd_mux : '0;
      end
   endgenerate

   assign enable    = ctl_q[EN_BIT];
   assign win_lower = lower_q;
   assign pt_base   = base_q;

   // R3
   lower_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(win_lower));

   // R3
   lower_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_lower[XW-1] && (win_lower[MIN_WIN_LG-1:0] == '0));

endmodule

// File: rtl/iomxu_addr.sv
module iomxu_addr
   import iomxu_pkg::*;
(
   input  logic          enable,
   input  logic [XW-1:0] dva,
   input  logic [XW-1:0] win_lower,
   input  logic [XW-1:0] pt_base,
   output logic          hit,
   output logic [XW-1:0] pte_addr
);

   logic [XW-1:0] offs;
   logic [XW-1:0] idx;

   assign hit      = enable && (dva >= win_lower);
   assign offs     = dva - win_lower;
   assign idx      = (offs >> IDX_SHIFT) & ~XW'(3);
   assign pte_addr = (pt_base << BASE_SHIFT) + idx;

endmodule

// File: rtl/iomxu_walk.sv
module iomxu_walk
   import iomxu_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_hit,
   input  logic [XW-1:0] pte_addr,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [XW-1:0] req_dva,
   output logic          rsp_valid,
   input  logic          rsp_ready,
   output logic [1:0]    rsp_status,
   output logic [XW-1:0] rsp_pa,
   output logic [XW-1:0] rsp_dva,
   output logic          rsp_cache,
   output logic          mem_req,
   input  logic          mem_gnt,
   output logic [XW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [XW-1:0] mem_rdata
);

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} wst_e;

   wst_e          st_q;
   logic [XW-1:0] dva_q;
   logic [XW-1:0] maddr_q;
   logic [XW-1:0] pa_q;
   logic          wr_q;
   logic          cache_q;
   xl_status_e    stat_q;
   logic          accept;
   logic          unused_pte;

   assign accept     = req_valid && req_ready;
   assign unused_pte = ^{mem_rdata[XW-1:PPN_MSB+1], mem_rdata[6:3], mem_rdata[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         dva_q   <= '0;
         maddr_q <= '0;
         pa_q    <= '0;
         wr_q    <= 1'b0;
         cache_q <= 1'b0;
         stat_q  <= XS_OK;
      end else begin
         case (st_q)
            ST_IDLE: if (accept) begin
               dva_q <= req_dva;
               wr_q  <= req_write;
               if (win_hit) begin
                  maddr_q <= pte_addr;
                  st_q    <= ST_FETCH;
               end else begin
                  stat_q  <= XS_RANGE;
                  pa_q    <= '0;
                  cache_q <= 1'b0;
                  st_q    <= ST_RESP;
               end
            end
            ST_FETCH: if (mem_gnt) st_q <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               st_q <= ST_RESP;
               if (!mem_rdata[PTE_V_BIT]) begin
                  stat_q  <= XS_INVALID;
                  pa_q    <= '0;
                  cache_q <= 1'b0;
               end else if (wr_q && !mem_rdata[PTE_W_BIT]) begin
                  stat_q  <= XS_WPROT;
                  pa_q    <= '0;
                  cache_q <= 1'b0;
               end else begin
                  stat_q  <= XS_OK;
                  pa_q    <= {1'b0, mem_rdata[PPN_MSB:PPN_LSB], dva_q[PG_SHIFT-1:0]};
                  cache_q <= mem_rdata[PTE_C_BIT];
               end
            end
            ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign mem_req    = (st_q == ST_FETCH);
   assign mem_addr   = maddr_q;
   assign rsp_valid  = (st_q == ST_RESP);
   assign rsp_status = stat_q;
   assign rsp_pa     = pa_q;
   assign rsp_dva    = dva_q;
   assign rsp_cache  = cache_q;

   // R9
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   rsp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R10
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_status)
                                     && $stable(rsp_dva) && $stable(rsp_cache)));

   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   // R4
   miss_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !win_hit) |=> (rsp_valid && !mem_req && rsp_status == 2'b01));

endmodule

// File: rtl/iomxu_top.sv
module iomxu_top
   import iomxu_pkg::*;
#(
   parameter int         REG_AW    = 2,
   parameter bit         RDATA_REG = 1'b1,
   parameter logic [3:0] IMPL_ID   = 4'h1,
   parameter logic [3:0] VER_ID    = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [31:0]       req_dva,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_status,
   output logic [31:0]       rsp_pa,
   output logic [31:0]       rsp_dva,
   output logic              rsp_cache,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic [31:0]       mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata
);

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("iomxu_top: REG_AW must be in 1..8");
      end
      if (XW != 32) begin : g_bad_xw
         $error("iomxu_top: datapath must be 32 bits");
      end
   endgenerate

   logic          enable;
   logic [XW-1:0] win_lower;
   logic [XW-1:0] pt_base;
   logic          win_hit;
   logic [XW-1:0] pte_addr;

   iomxu_regs #(
      .REG_AW    (REG_AW),
      .RDATA_REG (RDATA_REG),
      .IMPL_ID   (IMPL_ID),
      .VER_ID    (VER_ID)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .rd_en     (cfg_rd),
      .addr      (cfg_addr),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .enable    (enable),
      .win_lower (win_lower),
      .pt_base   (pt_base)
   );

   iomxu_addr u_addr (
      .enable    (enable),
      .dva       (req_dva),
      .win_lower (win_lower),
      .pt_base   (pt_base),
      .hit       (win_hit),
      .pte_addr  (pte_addr)
   );

   iomxu_walk u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_hit    (win_hit),
      .pte_addr   (pte_addr),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_dva    (req_dva),
      .rsp_valid  (rsp_valid),
      .rsp_ready  (rsp_ready),
      .rsp_status (rsp_status),
      .rsp_pa     (rsp_pa),
      .rsp_dva    (rsp_dva),
      .rsp_cache  (rsp_cache),
      .mem_req    (mem_req),
      .mem_gnt    (mem_gnt),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata)
   );

endmodule

// File: tb/iomxu_top_tb_top.sv
`timescale 1ns/1ps
module iomxu_top_tb_top;

   localparam int         AW   = 2;
   localparam logic [3:0] IMPL = 4'hA;
   localparam logic [3:0] VER  = 4'h5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0, cfg_rd = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0, cfg_rdata;
   logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [31:0]   req_dva = '0;
   logic          rsp_valid, rsp_ready = 1'b0, rsp_cache;
   logic [1:0]    rsp_status;
   logic [31:0]   rsp_pa, rsp_dva;
   logic          mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [31:0]   mem_addr, mem_rdata = '0;

   iomxu_top #(.REG_AW(AW), .RDATA_REG(1'b1), .IMPL_ID(IMPL), .VER_ID(VER)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_dva(req_dva),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
      .rsp_pa(rsp_pa), .rsp_dva(rsp_dva), .rsp_cache(rsp_cache), .mem_req(mem_req),
      .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

   always #10 clk = ~clk;

   int total = 0, bad = 0;
   int fetch_cnt = 0;
   int gnt_delay = 0, rd_lat = 0;
   logic [31:0] seen_addr = '0;
   logic [31:0] pmem [logic [31:0]];
   bit outstanding = 1'b0;

   // reference state kept by the bench
   bit          m_en = 1'b0;
   logic [2:0]  m_code = 3'd0;
   logic [31:0] m_base = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] lower_of(input logic [2:0] c);
      longint unsigned sz;
      sz = 64'd1 << (24 + int'(c));
      return 32'(64'h1_0000_0000 - sz);
   endfunction

   // per-cycle model: R9 ready follows outstanding translation
   always @(posedge clk) begin
      if (!rst_n) outstanding <= 1'b0;
      else if (req_valid && req_ready) outstanding <= 1'b1;
      else if (rsp_valid && rsp_ready) outstanding <= 1'b0;
   end
   always @(negedge clk) begin
      if (rst_n) chk(req_ready == !outstanding, "R9 ready", 32'(req_ready), 32'(!outstanding));
   end

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req && !mem_gnt) begin
            repeat (gnt_delay) begin
               @(negedge clk);
               chk(mem_req == 1'b1, "R10 mem_req held", 32'(mem_req), 32'h1);
            end
            seen_addr = mem_addr;
            mem_gnt   = 1'b1;
            fetch_cnt++;
            @(negedge clk);
            mem_gnt = 1'b0;
            repeat (rd_lat) @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata  = pmem.exists(seen_addr) ? pmem[seen_addr] : 32'h0;
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
      end
   end

   task automatic reg_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (a == 0) begin m_en = d[0]; m_code = d[4:2]; end
      if (a == 1) m_base = d;
   endtask

   task automatic reg_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      cfg_rd = 1'b1; cfg_addr = AW'(a);
      @(negedge clk);
      cfg_rd = 1'b0;
      d = cfg_rdata;
   endtask

   function automatic logic [31:0] mk_pte(input logic [18:0] ppn, input bit c, input bit w, input bit v);
      return {5'b0, ppn, c, 4'b0, w, v, 1'b0};
   endfunction

   task automatic trans(input logic [31:0] dva, input bit wr, input logic [18:0] ppn,
                        input bit c, input bit w, input bit v, input int hold, input string tag);
      logic [31:0] lo, eaddr, epa;
      logic [1:0]  est;
      bit          ec, miss;
      int          f0;
      lo    = lower_of(m_code);
      miss  = !m_en || (dva < lo);
      eaddr = (m_base << 4) + (((dva - lo) >> 10) & ~32'h3);
      if (!miss) pmem[eaddr] = mk_pte(ppn, c, w, v);
      if (miss)            begin est = 2'b01; epa = '0; ec = 1'b0; end
      else if (!v)         begin est = 2'b10; epa = '0; ec = 1'b0; end
      else if (wr && !w)   begin est = 2'b11; epa = '0; ec = 1'b0; end
      else                 begin est = 2'b00; epa = {1'b0, ppn, dva[11:0]}; ec = c; end
      f0 = fetch_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_dva = dva; req_write = wr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_dva = 32'hDEAD_BEEF; req_write = 1'b0;
      while (!rsp_valid) @(negedge clk);
      chk(rsp_status == est, {tag, " status"}, 32'(rsp_status), 32'(est));
      chk(rsp_pa == epa, {tag, " pa"}, rsp_pa, epa);
      chk(rsp_cache == ec, {tag, " cache"}, 32'(rsp_cache), 32'(ec));
      chk(rsp_dva == dva, "R11 dva echo", rsp_dva, dva);
      chk((fetch_cnt - f0) == (miss ? 0 : 1), {tag, " fetch count"}, 32'(fetch_cnt - f0), miss ? 32'd0 : 32'd1);
      if (!miss) chk(seen_addr == eaddr, "R5 entry address", seen_addr, eaddr);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk(rsp_valid && rsp_pa == epa && rsp_status == est && rsp_dva == dva,
             "R10 response held", rsp_pa, epa);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [2:0]  codes [3];
      codes[0] = 3'd0; codes[1] = 3'd3; codes[2] = 3'd7;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      reg_rd(0, d); chk(d == {IMPL, VER, 24'h0}, "R1 ctrl reset", d, {IMPL, VER, 24'h0});
      reg_rd(1, d); chk(d == 32'h0, "R1 base reset", d, 32'h0);
      trans(32'hFFFF_0000, 1'b0, 19'h0, 1'b0, 1'b0, 1'b0, 0, "R1 disabled after reset");

      // R2 register map
      reg_wr(0, 32'hFFFF_FFFE);
      reg_rd(0, d); chk(d == {IMPL, VER, 24'hFF_FFFE}, "R2 ro id ignored", d, {IMPL, VER, 24'hFF_FFFE});
      reg_wr(1, 32'h0012_3450);
      reg_rd(1, d); chk(d == 32'h0012_3450, "R2 base rw", d, 32'h0012_3450);
      reg_rd(2, d); chk(d == 32'h0, "R2 word2 zero", d, 32'h0);
      reg_rd(3, d); chk(d == 32'h0, "R2 word3 zero", d, 32'h0);
      // R4 enable clear (bit0 = 0) with code 7 window: in-window request still misses
      trans(32'hF000_1234, 1'b0, 19'h1, 1'b1, 1'b1, 1'b1, 0, "R4 disabled miss");

      // R3 R5 R6 window sizes and edges
      foreach (codes[k]) begin
         reg_wr(0, 32'h1 | (32'(codes[k]) << 2));
         gnt_delay = k; rd_lat = 2 - k;
         trans(lower_of(codes[k]), 1'b0, 19'h2A5F3 ^ 19'(k), 1'b1, 1'b0, 1'b1, 0, "R3 R6 window first byte");
         trans(32'hFFFF_FABC, 1'b1, 19'h12345 + 19'(k), 1'b0, 1'b1, 1'b1, 1, "R5 R6 last page");
         trans(lower_of(codes[k]) - 32'h1, 1'b0, 19'h0, 1'b0, 1'b1, 1'b1, 0, "R3 R4 below window");
      end

      // R7 invalid entries
      reg_wr(0, 32'h1 | (32'd5 << 2));
      trans(32'hE801_2345, 1'b0, 19'h7FFFF, 1'b1, 1'b1, 1'b0, 0, "R7 invalid read");
      trans(32'hE801_2345, 1'b1, 19'h7FFFF, 1'b1, 1'b1, 1'b0, 0, "R7 invalid write");

      // R8 write protection
      gnt_delay = 3; rd_lat = 1;
      trans(32'hF123_4567, 1'b1, 19'h0ABCD, 1'b1, 1'b0, 1'b1, 3, "R8 write to ro page");
      trans(32'hF123_4567, 1'b0, 19'h0ABCD, 1'b1, 1'b0, 1'b1, 3, "R8 read of ro page");

      // R3 window lower bound updated by a later control write only
      reg_wr(1, 32'h0000_0100);
      trans(32'hE000_0000, 1'b0, 19'h00001, 1'b0, 1'b0, 1'b1, 0, "R3 code5 bound");
      reg_wr(0, 32'h1);
      trans(32'hE000_0000, 1'b0, 19'h00001, 1'b0, 1'b0, 1'b1, 0, "R3 code0 after rewrite");

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule